// File: doc/BRIEF.md
# Iterative Waveform Update Timing Generator

This block paces hardware-timed waveform playback. A start trigger begins a run. After an optional lead delay, the block issues a train of single-cycle update strobes, one update interval apart. Each strobe carries the index of the buffered sample that the converter path should fetch and write. One train of strobes forms an iteration. Iterations repeat a programmed number of times, or without end, and an optional gap can separate them. A busy flag stays high for the whole run.

All settings are captured in the cycle the start trigger is accepted, so software may rewrite them while a run is in progress. A stop trigger never cuts an iteration short. It lets the current iteration finish its last update period and then ends the run. The unit of time is one clock cycle, which serves as the timebase tick.

Top module: `wfg_timing_gen`

## Requirements
- R1: After reset, `wfg_busy` and `upd_strobe` are low and `sample_idx` is zero.
- R2: A start trigger sampled at clock edge k while idle raises `wfg_busy` in the cycle after edge k. The first strobe is visible after edge k+1+L, where L is `cfg_lead` when `cfg_lead_en` is 1 and 0 otherwise.
- R3: Within an iteration, strobes are exactly P cycles apart, where P is `cfg_interval`, or 40 when `cfg_interval` is below 40.
- R4: Each iteration issues N strobes, where N is `cfg_updates`, or 1 when `cfg_updates` is 0. Each strobe is high for one cycle.
- R5: Each strobe presents `sample_idx` = 0, 1, … N-1 in order, and the index restarts at 0 with every iteration.
- R6: The first strobe of a following iteration comes P+G+1 cycles after the last strobe of the previous iteration, where G is `cfg_gap`.
- R7: With `cfg_forever` at 0, the run has M iterations, where M is `cfg_iterations`, or 1 when it is 0. `wfg_busy` falls P cycles after the final strobe.
- R8: With `cfg_forever` at 1, iterations repeat until a stop trigger is seen. The iteration in progress then completes, and `wfg_busy` falls P cycles after its last strobe. This also holds for a stop sampled on the very edge where that iteration ends. A stop in finite mode ends the run the same way.
- R9: A start trigger while busy, a change of any setting while busy, and a stop trigger while idle all leave the run's strobe timing, indices and end time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timebase tick |
| rst | input | 1 | Synchronous active-high reset |
| start_trig | input | 1 | Start trigger, one cycle |
| stop_trig | input | 1 | Stop trigger, one cycle |
| cfg_interval | input | 24 | Update interval in cycles, minimum 40 |
| cfg_updates | input | 16 | Strobes per iteration |
| cfg_iterations | input | 16 | Iteration count in finite mode |
| cfg_forever | input | 1 | 1 = repeat until stopped |
| cfg_lead_en | input | 1 | Enable the lead delay after start |
| cfg_lead | input | 24 | Lead delay in cycles |
| cfg_gap | input | 24 | Extra delay between iterations |
| upd_strobe | output | 1 | Update strobe and sample read request |
| sample_idx | output | 16 | Sample index that goes with the strobe |
| wfg_busy | output | 1 | High while a waveform run is in progress |

## Verification
The sharpest collision is a stop trigger that arrives on the same edge where an iteration's last update period ends. The end-of-iteration decision and the stop capture then fall in one cycle. The bench aims a stop at exactly that edge in both finite and endless runs, and it also issues stops at the first strobe of a chosen iteration. In every case the run must end after that iteration with no extra strobe. A second overlap, a start trigger together with new settings during a running iteration, is provoked mid-run and judged by an unchanged strobe schedule.

// File: rtl/wfg_pkg.sv
package wfg_pkg;

    localparam int IVL_W   = 24;
    localparam int UPD_W   = 16;
    localparam int ITER_W  = 16;
    localparam int DLY_W   = 24;
    localparam int MIN_IVL = 40;
    localparam int TMR_W   = (IVL_W > DLY_W) ? IVL_W : DLY_W;
    localparam int SPC_W   = $clog2(MIN_IVL) + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } wfg_state_e;

    typedef struct packed {
        logic [IVL_W-1:0]  period;
        logic [UPD_W-1:0]  n_upd;
        logic [ITER_W-1:0] n_iter;
        logic              forever_mode;
        logic [DLY_W-1:0]  gap;
    } wfg_cfg_t;

    function automatic logic [IVL_W-1:0] clamp_period(input logic [IVL_W-1:0] v);
        return (v < IVL_W'(MIN_IVL)) ? IVL_W'(MIN_IVL) : v;
    endfunction

    function automatic logic [UPD_W-1:0] upd_at_least_one(input logic [UPD_W-1:0] v);
        return (v == '0) ? UPD_W'(1) : v;
    endfunction

    function automatic logic [ITER_W-1:0] iter_at_least_one(input logic [ITER_W-1:0] v);
        return (v == '0) ? ITER_W'(1) : v;
    endfunction

endpackage

// File: rtl/wfg_cfg_latch.sv
module wfg_cfg_latch
    import wfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [IVL_W-1:0]  raw_interval,
    input  logic [UPD_W-1:0]  raw_updates,
    input  logic [ITER_W-1:0] raw_iterations,
    input  logic              raw_forever,
    input  logic              raw_lead_en,
    input  logic [DLY_W-1:0]  raw_lead,
    input  logic [DLY_W-1:0]  raw_gap,
    output wfg_cfg_t          cfg_q,
    output logic [DLY_W-1:0]  lead_d
);

    wfg_cfg_t cfg_d;

    always_comb begin
        cfg_d.period       = clamp_period(raw_interval);
        cfg_d.n_upd        = upd_at_least_one(raw_updates);
        cfg_d.n_iter       = iter_at_least_one(raw_iterations);
        cfg_d.forever_mode = raw_forever;
        cfg_d.gap          = raw_gap;
        lead_d             = raw_lead_en ? raw_lead : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.period       <= IVL_W'(MIN_IVL);
            cfg_q.n_upd        <= UPD_W'(1);
            cfg_q.n_iter       <= ITER_W'(1);
            cfg_q.forever_mode <= 1'b0;
            cfg_q.gap          <= '0;
        end else if (capture) begin
            cfg_q <= cfg_d;
        end
    end

    // R3
    period_floor_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> (cfg_q.period >= IVL_W'(MIN_IVL)));

endmodule

// File: rtl/wfg_tick_timer.sv
module wfg_tick_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

    // R3
    tick_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/wfg_event_ctr.sv
module wfg_event_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= inc ? W'(1) : '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/wfg_timing_gen.sv
module wfg_timing_gen
    import wfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_trig,
    input  logic              stop_trig,
    input  logic [IVL_W-1:0]  cfg_interval,
    input  logic [UPD_W-1:0]  cfg_updates,
    input  logic [ITER_W-1:0] cfg_iterations,
    input  logic              cfg_forever,
    input  logic              cfg_lead_en,
    input  logic [DLY_W-1:0]  cfg_lead,
    input  logic [DLY_W-1:0]  cfg_gap,
    output logic              upd_strobe,
    output logic [UPD_W-1:0]  sample_idx,
    output logic              wfg_busy
);

    wfg_state_e        state;
    wfg_cfg_t          cfg_q;
    logic [DLY_W-1:0]  lead_d;
    logic              accept;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic [UPD_W-1:0]  upd_cnt;
    logic [ITER_W-1:0] iter_cnt;
    logic              fire_first;
    logic              fire_next;
    logic              more;
    logic              iter_end;
    logic              last_iter;
    logic              finish;
    logic              stop_pend;
    logic [TMR_W-1:0]  period_m1;

    assign accept     = (state == ST_IDLE) && start_trig;
    assign more       = (upd_cnt < cfg_q.n_upd);
    assign fire_first = (state == ST_WAIT) && tmr_zero;
    assign fire_next  = (state == ST_RUN) && tmr_zero && more;
    assign iter_end   = (state == ST_RUN) && tmr_zero && !more;
    assign last_iter  = !cfg_q.forever_mode &&
                        (({1'b0, iter_cnt} + (ITER_W+1)'(1)) >= {1'b0, cfg_q.n_iter});
    assign finish     = last_iter || stop_pend || stop_trig;
    assign period_m1  = TMR_W'(cfg_q.period) - TMR_W'(1);

    wfg_cfg_latch u_cfg (
        .clk            (clk),
        .rst            (rst),
        .capture        (accept),
        .raw_interval   (cfg_interval),
        .raw_updates    (cfg_updates),
        .raw_iterations (cfg_iterations),
        .raw_forever    (cfg_forever),
        .raw_lead_en    (cfg_lead_en),
        .raw_lead       (cfg_lead),
        .raw_gap        (cfg_gap),
        .cfg_q          (cfg_q),
        .lead_d         (lead_d)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (start_trig) begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(lead_d);
            end
            ST_WAIT: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = period_m1;
            end
            ST_RUN: if (tmr_zero) begin
                if (more) begin
                    tmr_load = 1'b1;
                    tmr_val  = period_m1;
                end else if (!finish) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(cfg_q.gap);
                end
            end
            default: ;
        endcase
    end

    wfg_tick_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    wfg_event_ctr #(.W(UPD_W)) u_upd_ctr (
        .clk   (clk),
        .rst   (rst),
        .clr   (fire_first),
        .inc   (fire_first || fire_next),
        .count (upd_cnt)
    );

    wfg_event_ctr #(.W(ITER_W)) u_iter_ctr (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .inc   (iter_end),
        .count (iter_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            wfg_busy   <= 1'b0;
            upd_strobe <= 1'b0;
            sample_idx <= '0;
            stop_pend  <= 1'b0;
        end else begin
            upd_strobe <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    stop_pend <= 1'b0;
                    if (start_trig) begin
                        state    <= ST_WAIT;
                        wfg_busy <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (stop_trig) stop_pend <= 1'b1;
                    if (tmr_zero) begin
                        state      <= ST_RUN;
                        upd_strobe <= 1'b1;
                        sample_idx <= '0;
                    end
                end
                ST_RUN: begin
                    if (stop_trig) stop_pend <= 1'b1;
                    if (tmr_zero) begin
                        if (more) begin
                            upd_strobe <= 1'b1;
                            sample_idx <= upd_cnt;
                        end else if (finish) begin
                            state    <= ST_IDLE;
                            wfg_busy <= 1'b0;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic [SPC_W-1:0] since_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            if (upd_strobe) since_q <= '0;
            else if (since_q != {SPC_W{1'b1}}) since_q <= since_q + SPC_W'(1);
            if (!wfg_busy) seen_q <= 1'b0;
            else if (upd_strobe) seen_q <= 1'b1;
        end
    end

    // R2
    strobe_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |-> wfg_busy);

    // R3
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe && seen_q) |-> (since_q >= SPC_W'(MIN_IVL - 1)));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |=> !upd_strobe);

    // R5
    first_index_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe && $past(state == ST_WAIT)) |-> (sample_idx == '0));

    // R5
    index_bound_chk: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |-> (sample_idx < cfg_q.n_upd));

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wfg_busy) |-> ($past(state == ST_RUN) && $past(tmr_zero)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((state != ST_IDLE) && start_trig) |=> $stable(cfg_q));

endmodule

// File: tb/wfg_timing_gen_tb.sv
module wfg_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_trig, stop_trig;
    logic [23:0] cfg_interval;
    logic [15:0] cfg_updates, cfg_iterations;
    logic        cfg_forever, cfg_lead_en;
    logic [23:0] cfg_lead, cfg_gap;
    logic        upd_strobe;
    logic [15:0] sample_idx;
    logic        wfg_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wfg_timing_gen u_dut (
        .clk(clk), .rst(rst), .start_trig(start_trig), .stop_trig(stop_trig),
        .cfg_interval(cfg_interval), .cfg_updates(cfg_updates),
        .cfg_iterations(cfg_iterations), .cfg_forever(cfg_forever),
        .cfg_lead_en(cfg_lead_en), .cfg_lead(cfg_lead), .cfg_gap(cfg_gap),
        .upd_strobe(upd_strobe), .sample_idx(sample_idx), .wfg_busy(wfg_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_period(input int v);  return (v < 40) ? 40 : v; endfunction
    function automatic int at_least1(input int v);   return (v == 0) ? 1 : v;  endfunction

    // expected sample time (cycles after the start edge) of strobe j in iteration i
    function automatic int strobe_at(input int lead, input int p, input int n,
                                     input int g, input int i, input int j);
        return lead + 1 + i * (n * p + g + 1) + j * p;
    endfunction

    task automatic run_case(input int ivl, input int nupd, input int nit, input bit inf,
                            input bit den, input int dly, input int gap,
                            input int stop_iter, input bit stop_at_end, input bit poke);
        int p, n, m, lead, iters, stop_n, cnt, end_n, idx_exp;
        int act_t[64];
        int act_i[64];
        p    = eff_period(ivl);
        n    = at_least1(nupd);
        m    = at_least1(nit);
        lead = den ? dly : 0;
        if (stop_iter >= 0) begin
            iters = inf ? stop_iter + 1 : ((m < stop_iter + 1) ? m : stop_iter + 1);
        end else begin
            iters = m;
        end
        stop_n = -1;
        if (stop_iter >= 0)
            stop_n = stop_at_end ? strobe_at(lead, p, n, gap, stop_iter, n) - 1
                                 : strobe_at(lead, p, n, gap, stop_iter, 0);
        @(negedge clk);
        cfg_interval = 24'(ivl); cfg_updates = 16'(nupd); cfg_iterations = 16'(nit);
        cfg_forever = inf; cfg_lead_en = den; cfg_lead = 24'(dly); cfg_gap = 24'(gap);
        start_trig = 1'b1;
        @(negedge clk);
        start_trig = 1'b0;
        cnt = 0; end_n = -1;
        for (int t = 0; t < 6000; t++) begin
            if (t == 0) chk(wfg_busy === 1'b1, "R2 busy after start", int'(wfg_busy), 1);
            if (upd_strobe === 1'b1) begin
                if (cnt < 64) begin act_t[cnt] = t; act_i[cnt] = int'(sample_idx); end
                cnt++;
            end
            if (t > 0 && wfg_busy !== 1'b1) begin end_n = t; break; end
            stop_trig = (t == stop_n);
            if (poke && t == 3) begin
                start_trig = 1'b1;
                cfg_interval = 24'(ivl + 17); cfg_updates = 16'(nupd + 2);
                cfg_iterations = 16'(nit + 1); cfg_gap = 24'(gap + 9); cfg_forever = ~inf;
            end else begin
                start_trig = 1'b0;
            end
            @(negedge clk);
        end
        stop_trig = 1'b0; start_trig = 1'b0;
        chk(cnt == iters * n, inf ? "R8 strobe total" : "R7 strobe total", cnt, iters * n);
        for (int k = 0; k < cnt && k < iters * n && k < 64; k++) begin
            idx_exp = k % n;
            // R2 first strobe, R3 spacing, R6 gap between iterations
            chk(act_t[k] == strobe_at(lead, p, n, gap, k / n, idx_exp),
                (k == 0) ? "R2 first strobe time" : (idx_exp == 0 ? "R6 iteration start" : "R3 strobe spacing"),
                act_t[k], strobe_at(lead, p, n, gap, k / n, idx_exp));
            chk(act_i[k] == idx_exp, "R5 sample index", act_i[k], idx_exp);
        end
        chk(end_n == strobe_at(lead, p, n, gap, iters - 1, n),
            (stop_iter >= 0) ? "R8 run end" : "R7 run end",
            end_n, strobe_at(lead, p, n, gap, iters - 1, n));
        repeat (3) begin
            @(negedge clk);
            chk(upd_strobe === 1'b0 && wfg_busy === 1'b0, "R4 quiet after run",
                int'(upd_strobe) + int'(wfg_busy), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start_trig = 1'b0; stop_trig = 1'b0;
        cfg_interval = '0; cfg_updates = '0; cfg_iterations = '0;
        cfg_forever = 1'b0; cfg_lead_en = 1'b0; cfg_lead = '0; cfg_gap = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(wfg_busy === 1'b0, "R1 busy", int'(wfg_busy), 0);
        chk(upd_strobe === 1'b0, "R1 strobe", int'(upd_strobe), 0);
        chk(sample_idx === 16'd0, "R1 index", int'(sample_idx), 0);
        // R9 stop while idle has no effect
        stop_trig = 1'b1;
        @(negedge clk);
        stop_trig = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(wfg_busy === 1'b0 && upd_strobe === 1'b0, "R9 idle stop ignored",
                int'(wfg_busy) + int'(upd_strobe), 0);
        end
        run_case(45, 3, 2, 1'b0, 1'b0, 0, 0, -1, 1'b0, 1'b0);  // R9 run after idle stop
        run_case(10, 3, 2, 1'b0, 1'b1, 5, 4, -1, 1'b0, 1'b0);  // R3 clamp, R2 lead
        run_case(40, 1, 1, 1'b0, 1'b0, 0, 0, -1, 1'b0, 1'b0);  // minimum run
        run_case(41, 0, 0, 1'b0, 1'b1, 0, 7, -1, 1'b0, 1'b0);  // R4/R7 zero counts
        run_case(50, 4, 0, 1'b1, 1'b1, 3, 6, 2, 1'b0, 1'b0);   // R8 stop mid iteration
        run_case(42, 2, 0, 1'b1, 1'b0, 0, 2, 1, 1'b1, 1'b0);   // R8 stop on iteration end edge
        run_case(43, 3, 4, 1'b0, 1'b0, 0, 3, 1, 1'b1, 1'b0);   // R8 finite stop at end edge
        run_case(55, 3, 2, 1'b0, 1'b1, 2, 5, -1, 1'b0, 1'b1);  // R9 start+cfg while busy
        run_case(39, 5, 3, 1'b0, 1'b0, 0, 0, -1, 1'b0, 1'b0);  // R6 zero gap
        void'($urandom(32'h5EED_0042));
        for (int r = 0; r < 20; r++) begin
            int ivl, nu, ni, dl, gp, si;
            bit inf, den, sae, pk;
            ivl = int'($urandom_range(0, 70));
            nu  = int'($urandom_range(0, 5));
            ni  = int'($urandom_range(0, 4));
            dl  = int'($urandom_range(0, 12));
            gp  = int'($urandom_range(0, 12));
            inf = 1'($urandom_range(0, 1));
            den = 1'($urandom_range(0, 1));
            sae = 1'($urandom_range(0, 1));
            pk  = 1'($urandom_range(0, 1));
            si  = inf ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 4)) - 1;
            run_case(ivl, nu, ni, inf, den, dl, gp, si, sae, pk);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule